// File: doc/BRIEF.md
# Paused-boundary single-address block DMA engine

The block moves data between an SD card data port and system memory, one fixed-size block at a time. Software sets a block size, a block count, a mode word and a linear system address. A transfer starts when software writes the top byte of that address. In the card-to-memory direction each block is first fetched from the card into a local block buffer and then written to memory one byte per bus acknowledge. In the memory-to-card direction the buffer is filled from memory and then pushed to the card.

Memory traffic is cut at a programmable address boundary. When the next address would land on a boundary while blocks remain, the engine stops, raises a one-cycle DMA interrupt pulse and keeps any half-moved block in its buffer. Software then rewrites the top byte of the address to continue. While the engine is moving data it ignores writes to the address and to the size/count register. Four present-state flags show whether a transfer is in progress, whether the data line is busy, and its direction.

Top module: `sdma_engine`

## Requirements
- R1: A start sets the inhibit and line-active flags, and sets exactly one of read-active (mode bit 0 = 1, card to memory) or write-active (mode bit 0 = 0, memory to card).
- R2: A start happens only on an address write whose byte enable 3 (bits 31:24) is set, with block count nonzero, block size nonzero and mode bits 3:2 equal to 0 (the single-address DMA mode). A write with byte enable 3 clear never starts one.
- R3: While data is moving (any bus or card handshake state), writes to the address register (select 0) and to the size/count register (select 1) have no effect.
- R4: In the size/count register (select 1) bits 11:0 are the block size (byte enables 0 and 1) and bits 31:16 are the block count (byte enables 2 and 3); only enabled bytes change.
- R5: A block size above the buffer capacity BUF_BYTES (64 by default) is stored as BUF_BYTES.
- R6: A size write that changes the stored size resets the buffer fill pointer, so a paused card-to-memory transfer resumes with a fresh card fetch; a write of the same size keeps the partial block.
- R7: The address advances by one for every byte acknowledged on the memory bus, and the count drops by one per completed block.
- R8: The boundary is 4096 bytes shifted left by mode bits 6:4. When a byte ends just below a boundary and blocks remain, the engine pauses with flags still set, pulses dma_irq for one cycle, and resumes on a top-byte address write, finishing the partial block first.
- R9: With mode bit 1 clear (single-block mode) exactly one block moves, the count drops by one and the transfer completes.
- R10: When the last block finishes, all four flags clear and xfer_done pulses for one cycle.
- R11: Card-to-memory writes the card byte stream to consecutive addresses; memory-to-card sends the bytes read from consecutive addresses to the card, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 size/count, 2 mode |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables for the write |
| sys_addr | output | 32 | Current system address |
| blk_size | output | 12 | Stored block size |
| blk_cnt | output | 16 | Remaining block count |
| card_rd_valid | input | 1 | Card offers a byte |
| card_rd_data | input | 8 | Byte from card |
| card_rd_ready | output | 1 | Engine takes a card byte |
| card_wr_valid | output | 1 | Engine offers a byte to the card |
| card_wr_data | output | 8 | Byte to card |
| card_wr_ready | input | 1 | Card takes the byte |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory completes the request |
| st_inhibit | output | 1 | Transfer in progress |
| st_line_active | output | 1 | Data line busy |
| st_read_active | output | 1 | Card-to-memory active |
| st_write_active | output | 1 | Memory-to-card active |
| dma_irq | output | 1 | One-cycle pulse at a boundary pause |
| xfer_done | output | 1 | One-cycle pulse at completion |

## Verification
A wrong fill pointer shows at the ports only after a pause is resumed: memory receives stale or repeated card bytes, or the card is asked for the wrong number of bytes, so the bench compares every byte landed at each address against the card stream. A wrong boundary mask appears within one byte as an early or missing dma_irq and a wrong sys_addr at the pause. A count or lock fault appears at completion as a wrong final address, count or size readback, checked the cycle after xfer_done.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int ADDR_W   = 32;
    localparam int SIZE_W   = 12;
    localparam int CNT_W    = 16;
    localparam int BND_BASE = 4096;

    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_SIZE = 2'd1;
    localparam logic [1:0] REG_MODE = 2'd2;
    localparam logic [1:0] DMA_SEL_SINGLE_ADDR = 2'd0;

    typedef enum logic [2:0] {
        S_IDLE, S_CARD_RD, S_MEM_WR, S_MEM_RD, S_CARD_WR, S_PAUSE
    } sdma_state_e;

    typedef struct packed {
        logic [2:0] bnd;
        logic [1:0] dma_sel;
        logic       multi;
        logic       dir_rd;
    } sdma_mode_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_wr,
    input  logic              mode_wr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [SIZE_W-1:0] blk_size,
    output sdma_mode_t        mode,
    output logic              size_chg
);
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        sdma_mode_t        mode;
    } regs_t;

    regs_t q, d;
    logic [SIZE_W-1:0] nsz;

    always_comb begin
        d   = q;
        nsz = q.size;
        if (be[0]) nsz[7:0]        = wdata[7:0];
        if (be[1]) nsz[SIZE_W-1:8] = wdata[SIZE_W-1:8];
        if (nsz > SIZE_W'(BUF_BYTES)) nsz = SIZE_W'(BUF_BYTES);
        size_chg = size_wr && (be[0] || be[1]) && (nsz != q.size);
        if (size_wr) d.size = nsz;
        if (mode_wr && be[0]) d.mode = sdma_mode_t'(wdata[6:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign blk_size = q.size;
    assign mode     = q.mode;
endmodule

// File: rtl/sdma_buffer.sv
module sdma_buffer #(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
    import sdma_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int IW = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [31:0]       sw_wdata,
    input  logic [3:0]        sw_be,
    input  logic [SIZE_W-1:0] blk_size,
    input  sdma_mode_t        mode,
    input  logic              size_chg,
    output logic [ADDR_W-1:0] sys_addr,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              moving,
    input  logic              card_rd_valid,
    input  logic [7:0]        card_rd_data,
    output logic              card_rd_ready,
    output logic              card_wr_valid,
    input  logic              card_wr_ready,
    output logic              mem_req,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              buf_we,
    output logic [IW-1:0]     buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic [IW-1:0]     buf_raddr,
    output logic              st_inhibit,
    output logic              st_line_active,
    output logic              st_read_active,
    output logic              st_write_active,
    output logic              dma_irq,
    output logic              xfer_done
);
    typedef struct packed {
        sdma_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [SIZE_W-1:0] ptr;
        logic [SIZE_W-1:0] cidx;
        logic              bnd_pend;
        logic              inhibit;
        logic              line;
        logic              rd_act;
        logic              wr_act;
        logic              irq;
        logic              done;
    } ctrl_t;

    ctrl_t q, d;
    logic idle_like, sw_addr, sw_size, start_ok;
    logic bnd_hit, last_byte, last_cidx, last_blk, fin, fin_hit;
    logic [ADDR_W-1:0] bnd_mask;
    sdma_state_e first_st;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        d.done = 1'b0;
        card_rd_ready = 1'b0;
        card_wr_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        buf_we    = 1'b0;
        buf_waddr = q.ptr[IW-1:0];
        buf_raddr = q.ptr[IW-1:0];
        buf_wdata = mem_rdata;
        fin       = 1'b0;
        fin_hit   = 1'b0;

        idle_like = (q.st == S_IDLE) || (q.st == S_PAUSE);
        sw_addr   = sw_wr && (sw_sel == REG_ADDR) && idle_like;
        sw_size   = sw_wr && (sw_sel == REG_SIZE) && idle_like;
        start_ok  = (q.cnt != '0) && (blk_size != '0) &&
                    (mode.dma_sel == DMA_SEL_SINGLE_ADDR);
        bnd_mask  = (ADDR_W'(BND_BASE) << mode.bnd) - ADDR_W'(1);
        bnd_hit   = ((q.addr + ADDR_W'(1)) & bnd_mask) == '0;
        last_byte = (q.ptr + SIZE_W'(1)) == blk_size;
        last_cidx = (q.cidx + SIZE_W'(1)) == blk_size;
        last_blk  = (q.cnt == CNT_W'(1)) || !mode.multi;
        first_st  = mode.dir_rd ? ((q.ptr == '0) ? S_CARD_RD : S_MEM_WR) : S_MEM_RD;

        case (q.st)
            S_IDLE, S_PAUSE: begin
                if (sw_addr) begin
                    for (int b = 0; b < 4; b++)
                        if (sw_be[b]) d.addr[8*b +: 8] = sw_wdata[8*b +: 8];
                end
                if (sw_size) begin
                    if (sw_be[2]) d.cnt[7:0]  = sw_wdata[23:16];
                    if (sw_be[3]) d.cnt[15:8] = sw_wdata[31:24];
                end
                if (size_chg) d.ptr = '0;
                if (sw_addr && sw_be[3] && start_ok) begin
                    d.st      = first_st;
                    d.cidx    = '0;
                    d.inhibit = 1'b1;
                    d.line    = 1'b1;
                    d.rd_act  = mode.dir_rd;
                    d.wr_act  = !mode.dir_rd;
                end
            end
            S_CARD_RD: begin
                card_rd_ready = 1'b1;
                buf_waddr     = q.cidx[IW-1:0];
                buf_wdata     = card_rd_data;
                if (card_rd_valid) begin
                    buf_we = 1'b1;
                    d.cidx = q.cidx + SIZE_W'(1);
                    if (last_cidx) begin
                        d.st   = S_MEM_WR;
                        d.cidx = '0;
                    end
                end
            end
            S_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    d.addr = q.addr + ADDR_W'(1);
                    if (last_byte) begin
                        fin     = 1'b1;
                        fin_hit = bnd_hit;
                    end else begin
                        d.ptr = q.ptr + SIZE_W'(1);
                        if (bnd_hit) begin
                            d.st  = S_PAUSE;
                            d.irq = 1'b1;
                        end
                    end
                end
            end
            S_MEM_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    buf_we = 1'b1;
                    d.addr = q.addr + ADDR_W'(1);
                    if (last_byte) begin
                        d.st       = S_CARD_WR;
                        d.cidx     = '0;
                        d.bnd_pend = bnd_hit;
                    end else begin
                        d.ptr = q.ptr + SIZE_W'(1);
                        if (bnd_hit) begin
                            d.st  = S_PAUSE;
                            d.irq = 1'b1;
                        end
                    end
                end
            end
            S_CARD_WR: begin
                card_wr_valid = 1'b1;
                buf_raddr     = q.cidx[IW-1:0];
                if (card_wr_ready) begin
                    d.cidx = q.cidx + SIZE_W'(1);
                    if (last_cidx) begin
                        fin     = 1'b1;
                        fin_hit = q.bnd_pend;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            d.cnt  = q.cnt - CNT_W'(1);
            d.ptr  = '0;
            d.cidx = '0;
            if (last_blk) begin
                d.st      = S_IDLE;
                d.inhibit = 1'b0;
                d.line    = 1'b0;
                d.rd_act  = 1'b0;
                d.wr_act  = 1'b0;
                d.done    = 1'b1;
            end else if (fin_hit) begin
                d.st  = S_PAUSE;
                d.irq = 1'b1;
            end else begin
                d.st = mode.dir_rd ? S_CARD_RD : S_MEM_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    assign moving          = !idle_like;
    assign sys_addr        = q.addr;
    assign blk_cnt         = q.cnt;
    assign st_inhibit      = q.inhibit;
    assign st_line_active  = q.line;
    assign st_read_active  = q.rd_act;
    assign st_write_active = q.wr_act;
    assign dma_irq         = q.irq;
    assign xfer_done       = q.done;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_be,
    output logic [31:0] sys_addr,
    output logic [11:0] blk_size,
    output logic [15:0] blk_cnt,
    input  logic        card_rd_valid,
    input  logic [7:0]  card_rd_data,
    output logic        card_rd_ready,
    output logic        card_wr_valid,
    output logic [7:0]  card_wr_data,
    input  logic        card_wr_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ack,
    output logic        st_inhibit,
    output logic        st_line_active,
    output logic        st_read_active,
    output logic        st_write_active,
    output logic        dma_irq,
    output logic        xfer_done
);
    localparam int IW = $clog2(BUF_BYTES);

    logic          moving, size_wr, mode_wr, size_chg, buf_we;
    logic [IW-1:0] buf_waddr, buf_raddr;
    logic [7:0]    buf_wdata, buf_rdata;
    sdma_mode_t    mode;

    assign size_wr = reg_wr && (reg_sel == REG_SIZE) && !moving;
    assign mode_wr = reg_wr && (reg_sel == REG_MODE) && !st_inhibit;

    sdma_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .mode_wr(mode_wr),
        .wdata(reg_wdata), .be(reg_be), .blk_size(blk_size), .mode(mode),
        .size_chg(size_chg)
    );

    sdma_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_wr(reg_wr), .sw_sel(reg_sel),
        .sw_wdata(reg_wdata), .sw_be(reg_be), .blk_size(blk_size), .mode(mode),
        .size_chg(size_chg), .sys_addr(sys_addr), .blk_cnt(blk_cnt),
        .moving(moving), .card_rd_valid(card_rd_valid),
        .card_rd_data(card_rd_data), .card_rd_ready(card_rd_ready),
        .card_wr_valid(card_wr_valid), .card_wr_ready(card_wr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .buf_raddr(buf_raddr),
        .st_inhibit(st_inhibit), .st_line_active(st_line_active),
        .st_read_active(st_read_active), .st_write_active(st_write_active),
        .dma_irq(dma_irq), .xfer_done(xfer_done)
    );

    sdma_buffer #(.DEPTH(BUF_BYTES)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr(buf_raddr), .rdata(buf_rdata)
    );

    assign mem_addr     = sys_addr;
    assign mem_wdata    = buf_rdata;
    assign card_wr_data = buf_rdata;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker
    import sdma_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] sys_addr,
    input logic [11:0] blk_size,
    input logic [15:0] blk_cnt,
    input logic        card_rd_ready,
    input logic        card_wr_valid,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        st_inhibit,
    input logic        st_line_active,
    input logic        st_read_active,
    input logic        st_write_active,
    input logic        dma_irq,
    input logic        xfer_done
);
    logic moving;
    assign moving = mem_req || card_rd_ready || card_wr_valid;

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        st_inhibit |-> (st_read_active != st_write_active)); // R1
    AST_LINE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_inhibit) |-> st_line_active); // R1
    AST_START_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_inhibit) |-> ($past(blk_cnt) != '0) && (blk_size != '0)); // R2
    AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd_ready && reg_wr && reg_sel == REG_ADDR) |=> $stable(sys_addr)); // R3
    AST_SIZE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && reg_wr && reg_sel == REG_SIZE) |=> $stable(blk_size)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> sys_addr == $past(sys_addr) + 32'd1); // R7
    AST_PAUSE_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> st_inhibit && !moving); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |=> !dma_irq); // R8
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !st_inhibit && !st_line_active && !st_read_active && !st_write_active); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R10

    always @(posedge clk) begin
        if (rst_n) begin
            AST_SIZE_CLAMP: assert (blk_size <= SIZE_W'(BUF_BYTES)); // R5
        end
    end
endmodule

bind sdma_engine sdma_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .sys_addr(sys_addr), .blk_size(blk_size), .blk_cnt(blk_cnt),
    .card_rd_ready(card_rd_ready), .card_wr_valid(card_wr_valid),
    .mem_req(mem_req), .mem_ack(mem_ack), .st_inhibit(st_inhibit),
    .st_line_active(st_line_active), .st_read_active(st_read_active),
    .st_write_active(st_write_active), .dma_irq(dma_irq), .xfer_done(xfer_done)
);

// File: tb/sim_sdma_engine.sv
`timescale 1ns/1ps
module sim_sdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [3:0]  reg_be = 4'd0;
    logic [31:0] sys_addr, mem_addr;
    logic [11:0] blk_size;
    logic [15:0] blk_cnt;
    logic        card_rd_ready, card_wr_valid, mem_req, mem_we;
    logic [7:0]  card_rd_data, card_wr_data, mem_wdata, mem_rdata;
    logic        st_inhibit, st_line_active, st_read_active, st_write_active;
    logic        dma_irq, xfer_done;

    int checks = 0, errors = 0;
    int card_seq = 0, cw_cnt = 0, irq_cnt = 0, done_cnt = 0;
    logic [7:0] memv [16384];
    logic [7:0] cw_buf [256];

    always #5 clk = ~clk;

    assign card_rd_data = card_seq[7:0];
    assign mem_rdata    = mem_addr[7:0] ^ 8'hA5;

    sdma_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .sys_addr(sys_addr),
        .blk_size(blk_size), .blk_cnt(blk_cnt), .card_rd_valid(1'b1),
        .card_rd_data(card_rd_data), .card_rd_ready(card_rd_ready),
        .card_wr_valid(card_wr_valid), .card_wr_data(card_wr_data),
        .card_wr_ready(1'b1), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_req), .st_inhibit(st_inhibit),
        .st_line_active(st_line_active), .st_read_active(st_read_active),
        .st_write_active(st_write_active), .dma_irq(dma_irq), .xfer_done(xfer_done)
    );

    always @(posedge clk) begin
        if (card_rd_ready) card_seq <= card_seq + 1;
        if (card_wr_valid) begin
            cw_buf[cw_cnt[7:0]] <= card_wr_data;
            cw_cnt <= cw_cnt + 1;
        end
        if (mem_req && mem_we) memv[mem_addr[13:0]] <= mem_wdata;
        if (dma_irq) irq_cnt <= irq_cnt + 1;
        if (xfer_done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'd0;
    endtask

    task automatic wait_count(input bit want_irq, input int base);
        int n = 0;
        while (((want_irq ? irq_cnt : done_cnt) == base) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(want_irq ? "R8" : "R10", "event arrived", (n < 20000), 1);
    endtask

    task automatic t_reset();
        check("R10", "inhibit after reset", st_inhibit, 0);
        check("R10", "flags after reset", {st_line_active, st_read_active, st_write_active}, 0);
        check("R4", "size after reset", blk_size, 0);
        check("R7", "addr after reset", sys_addr, 0);
    endtask

    task automatic t_fields();
        wr(2'd1, 32'h0003_0010, 4'hF);
        check("R4", "size field", blk_size, 16);
        check("R4", "count field", blk_cnt, 3);
        wr(2'd1, 32'h0000_0064, 4'b0011);
        check("R5", "clamped size", blk_size, 64);
        check("R4", "count kept on size-only write", blk_cnt, 3);
        wr(2'd1, 32'h0007_0000, 4'b1100);
        check("R4", "count-only write", blk_cnt, 7);
        check("R4", "size kept on count-only write", blk_size, 64);
    endtask

    task automatic t_no_start();
        wr(2'd2, 32'h3, 4'h1);
        wr(2'd1, 32'h0000_0010, 4'hF);
        wr(2'd0, 32'h0000_0400, 4'hF);
        check("R2", "no start with zero count", st_inhibit, 0);
        wr(2'd1, 32'h0001_0000, 4'hF);
        wr(2'd0, 32'h0000_0400, 4'hF);
        check("R2", "no start with zero size", st_inhibit, 0);
        wr(2'd1, 32'h0001_0010, 4'hF);
        wr(2'd0, 32'h0000_0400, 4'b0111);
        check("R2", "no start on low-byte write", st_inhibit, 0);
        wr(2'd2, 32'h7, 4'h1);
        wr(2'd0, 32'h0000_0400, 4'hF);
        check("R2", "no start in other DMA mode", st_inhibit, 0);
        @(negedge clk);
        check("R2", "still idle", st_inhibit, 0);
    endtask

    task automatic t_read_multi();
        int s0 = card_seq, d0 = done_cnt, bad = 0;
        wr(2'd2, 32'h3, 4'h1);
        wr(2'd1, 32'h0003_0010, 4'hF);
        wr(2'd0, 32'h0000_0100, 4'hF);
        check("R1", "read-direction flags",
              {st_inhibit, st_line_active, st_read_active, st_write_active}, 4'b1110);
        wr(2'd0, 32'hDEAD_0000, 4'hF);
        wr(2'd1, 32'h0009_0008, 4'hF);
        wait_count(1'b0, d0);
        check("R3", "address write ignored while moving", sys_addr, 32'h130);
        check("R3", "size write ignored while moving", blk_size, 16);
        check("R7", "count drained", blk_cnt, 0);
        check("R10", "flags clear", {st_inhibit, st_line_active, st_read_active}, 0);
        @(negedge clk);
        check("R10", "one done pulse", done_cnt - d0, 1);
        for (int i = 0; i < 48; i++)
            if (memv[14'h100 + 14'(i)] != 8'(s0 + i)) bad++;
        check("R11", "card bytes at consecutive addresses", bad, 0);
        check("R11", "card bytes fetched", card_seq - s0, 48);
    endtask

    task automatic t_write_multi();
        int c0 = cw_cnt, d0 = done_cnt, bad = 0;
        wr(2'd2, 32'h2, 4'h1);
        wr(2'd1, 32'h0002_0008, 4'hF);
        wr(2'd0, 32'h0000_0200, 4'hF);
        check("R1", "write-direction flags",
              {st_inhibit, st_line_active, st_read_active, st_write_active}, 4'b1101);
        wait_count(1'b0, d0);
        check("R11", "bytes sent to card", cw_cnt - c0, 16);
        for (int i = 0; i < 16; i++)
            if (cw_buf[8'(c0 + i)] != (8'(32'h200 + i) ^ 8'hA5)) bad++;
        check("R11", "memory bytes reach card in order", bad, 0);
        check("R7", "write-direction address", sys_addr, 32'h210);
    endtask

    task automatic t_boundary();
        int s0 = card_seq, i0 = irq_cnt, d0 = done_cnt, bad = 0;
        wr(2'd2, 32'h3, 4'h1);
        wr(2'd1, 32'h0002_0010, 4'hF);
        wr(2'd0, 32'h0000_0FF8, 4'hF);
        wait_count(1'b1, i0);
        @(negedge clk);
        check("R8", "pause address", sys_addr, 32'h1000);
        check("R8", "count kept in pause", blk_cnt, 2);
        check("R8", "flags held in pause", st_inhibit, 1);
        check("R8", "no memory traffic in pause", mem_req, 0);
        check("R8", "single irq pulse", irq_cnt - i0, 1);
        check("R8", "whole block fetched", card_seq - s0, 16);
        wr(2'd1, 32'h0002_0010, 4'hF);
        wr(2'd0, 32'h0000_1000, 4'b1000);
        wait_count(1'b0, d0);
        for (int i = 0; i < 32; i++)
            if (memv[14'hFF8 + 14'(i)] != 8'(s0 + i)) bad++;
        check("R6", "same size keeps partial block", bad, 0);
        check("R8", "card fetches after resume", card_seq - s0, 32);
        check("R7", "final address after resume", sys_addr, 32'h1018);
        check("R7", "count after resume", blk_cnt, 0);
    endtask

    task automatic t_size_change();
        int s0 = card_seq, i0 = irq_cnt, d0 = done_cnt, bad = 0;
        wr(2'd1, 32'h0001_0010, 4'hF);
        wr(2'd0, 32'h0000_1FFC, 4'hF);
        wait_count(1'b1, i0);
        check("R8", "pause at 0x2000", sys_addr, 32'h2000);
        wr(2'd1, 32'h0001_0008, 4'hF);
        check("R6", "size written while paused", blk_size, 8);
        wr(2'd0, 32'h0000_2000, 4'b1000);
        wait_count(1'b0, d0);
        check("R6", "fresh card fetch after size change", card_seq - s0, 24);
        for (int i = 0; i < 8; i++)
            if (memv[14'h2000 + 14'(i)] != 8'(s0 + 16 + i)) bad++;
        check("R6", "new block lands at resume address", bad, 0);
        check("R7", "address after size change", sys_addr, 32'h2008);
    endtask

    task automatic t_single();
        int s0 = card_seq, d0 = done_cnt;
        wr(2'd2, 32'h1, 4'h1);
        wr(2'd1, 32'h0003_0008, 4'hF);
        wr(2'd0, 32'h0000_0300, 4'hF);
        wait_count(1'b0, d0);
        check("R9", "single block count", blk_cnt, 2);
        check("R9", "single block address", sys_addr, 32'h308);
        check("R9", "single block card bytes", card_seq - s0, 8);
    endtask

    task automatic t_wide_boundary();
        int i0 = irq_cnt, d0 = done_cnt;
        wr(2'd2, 32'h13, 4'h1);
        wr(2'd1, 32'h0001_0008, 4'hF);
        wr(2'd0, 32'h0000_0FFC, 4'hF);
        wait_count(1'b0, d0);
        check("R8", "no pause at 4K with 8K boundary", irq_cnt - i0, 0);
        check("R8", "address across 4K", sys_addr, 32'h1004);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_no_start();
        t_read_multi();
        t_write_multi();
        t_boundary();
        t_size_change();
        t_single();
        t_wide_boundary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule